// File: doc/BRIEF.md
# Debug Opcode and Address Match Trigger

This block observes a stream of cache requests, one candidate per clock, and emits a single-cycle debug pulse whenever a valid request agrees with a programmable pattern. The pattern is held in two 64-bit registers, a mask and a compare value. Three windows of these registers are used: two opcode fields taken from the request's instruction word and one physical-address field. Each window compares the masked request bits with the compare bits. A request triggers only when all three windows agree. The match pulse appears a fixed two cycles after the request is presented.

A second, independent output raises a one-cycle error-event pulse. It fires one cycle after debug triggering is enabled while any of four selected status bits is set. Two of these bits come from a fault-status word and two from a poisoned-data status word. Software loads the mask and compare registers through two write strobes that share one data bus.

Top module: `pa_match_trigger`

## Requirements
- R1: Opcode field A compares instruction bits [25:21], ANDed with mask bits [52:48], against compare bits [52:48].
- R2: Opcode field B compares instruction bits [18:13], ANDed with mask bits [45:40], against compare bits [45:40].
- R3: The address field compares request address bits [33:2], ANDed with mask bits [33:2], against compare bits [33:2].
- R4: A request with `req_valid` low never produces a match pulse, whatever its fields hold.
- R5: `match_pulse` is high exactly two clock cycles after a cycle in which a valid request satisfies every field comparison. In all other cycles it is low.
- R6: `err_event` is high exactly one cycle after a cycle in which `trig_en` is 1 and at least one of these bits is set: `fault_status[35]`, `fault_status[36]`, `poison_status[48]`, `poison_status[49]`. No other status bit has any effect.
- R7: All three field comparisons must hold in the same cycle. A mismatch in any single field suppresses the match.
- R8: Synchronous reset clears both registers and both outputs. With the cleared registers, every valid request matches.
- R9: When `mask_we` is high, the mask register loads `cfg_wdata`. When `cmp_we` is high, the compare register loads `cfg_wdata`. A request in the write cycle still sees the old value, and a request in the following cycle sees the new value.
- R10: Mask and compare bits outside the three field windows, and request bits outside them, have no effect on matching.
- R11: The compare value is applied literally. A compare bit of 1 under a mask bit of 0 makes that field never match.
- R12: Valid matching requests on consecutive cycles produce match pulses on consecutive cycles, neither merged nor stretched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mask_we | input | 1 | Load mask register from `cfg_wdata` |
| cmp_we | input | 1 | Load compare register from `cfg_wdata` |
| cfg_wdata | input | 64 | Register write data |
| req_valid | input | 1 | Request present this cycle |
| req_instr | input | INSTR_W (32) | Request instruction word |
| req_addr | input | ADDR_W (40) | Request physical address |
| trig_en | input | 1 | Debug trigger enable for the error event |
| fault_status | input | STATUS_W (64) | Fault status word (bits 35, 36 used) |
| poison_status | input | STATUS_W (64) | Poisoned-data status word (bits 48, 49 used) |
| match_pulse | output | 1 | Registered match pulse, two cycles after the request |
| err_event | output | 1 | Registered error-event pulse, one cycle after its condition |

## Verification
On every cycle, the bound checker recomputes the qualified match from the ports and the stored pattern. It requires the match pulse to equal that result as it stood two cycles earlier, and the error event to follow its condition by exactly one cycle. It also requires each register to hold its value whenever its write strobe is low. The directed scenarios are needed for the behaviour that depends on what the stored pattern is. These are the bit positions of each window, the literal treatment of a compare bit under a zero mask bit, and the write-cycle boundary. They also cover the cleared pattern that matches everything after reset and the absence of any effect from bits outside the windows.

// File: rtl/pamt_pkg.sv
package pamt_pkg;

    localparam int unsigned CFG_W = 64;

    // opcode field A: instruction window and register window
    localparam int unsigned OPA_SRC_LO = 21;
    localparam int unsigned OPA_CFG_LO = 48;
    localparam int unsigned OPA_W      = 5;
    // opcode field B
    localparam int unsigned OPB_SRC_LO = 13;
    localparam int unsigned OPB_CFG_LO = 40;
    localparam int unsigned OPB_W      = 6;
    // address field
    localparam int unsigned ADR_SRC_LO = 2;
    localparam int unsigned ADR_CFG_LO = 2;
    localparam int unsigned ADR_W      = 32;

    // status bits feeding the error event
    localparam int unsigned FLT_BIT_LO = 35;
    localparam int unsigned FLT_BIT_HI = 36;
    localparam int unsigned PSN_BIT_LO = 48;
    localparam int unsigned PSN_BIT_HI = 49;

    typedef struct packed {
        logic [CFG_W-1:0] mask;
        logic [CFG_W-1:0] cmpv;
    } trig_cfg_t;

    typedef struct packed {
        logic opa;
        logic opb;
        logic adr;
    } field_hits_t;

    // masked request bits must equal the compare bits, taken literally
    function automatic logic masked_equal(input logic [31:0] val,
                                          input logic [31:0] msk,
                                          input logic [31:0] cmpv);
        return ((val & msk) == cmpv);
    endfunction

endpackage

// File: rtl/pamt_cfg_regs.sv
module pamt_cfg_regs
    import pamt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mask_we,
    input  logic             cmp_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output trig_cfg_t        cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else begin
            if (mask_we) cfg_q.mask <= cfg_wdata;
            if (cmp_we)  cfg_q.cmpv <= cfg_wdata;
        end
    end

endmodule

// File: rtl/pamt_field_cmp.sv
module pamt_field_cmp
    import pamt_pkg::*;
#(
    parameter int unsigned SRC_W   = 32,
    parameter int unsigned SRC_LO  = 0,
    parameter int unsigned CFG_LO  = 0,
    parameter int unsigned FIELD_W = 4
) (
    input  logic [SRC_W-1:0] src,
    input  trig_cfg_t        cfg,
    output logic             hit
);

    logic [FIELD_W-1:0] val_f;
    logic [FIELD_W-1:0] msk_f;
    logic [FIELD_W-1:0] cmp_f;
    logic               unused_bits;

    assign val_f = src[SRC_LO +: FIELD_W];
    assign msk_f = cfg.mask[CFG_LO +: FIELD_W];
    assign cmp_f = cfg.cmpv[CFG_LO +: FIELD_W];

    assign hit = masked_equal(32'(val_f), 32'(msk_f), 32'(cmp_f));

    assign unused_bits = ^{src, cfg};

endmodule

// File: rtl/pamt_delay.sv
module pamt_delay #(
    parameter int unsigned DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    logic [DEPTH-1:0] stage;

    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) stage <= '0;
                else     stage <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) stage <= '0;
                else     stage <= {stage[DEPTH-2:0], d};
            end
        end
    endgenerate

    assign q = stage[DEPTH-1];

endmodule

// File: rtl/pamt_err_evt.sv
module pamt_err_evt
    import pamt_pkg::*;
#(
    parameter int unsigned STATUS_W = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                trig_en,
    input  logic [STATUS_W-1:0] fault_status,
    input  logic [STATUS_W-1:0] poison_status,
    output logic                evt
);

    logic sel_any;
    logic unused_status;

    assign sel_any = fault_status[FLT_BIT_LO]  | fault_status[FLT_BIT_HI] |
                     poison_status[PSN_BIT_LO] | poison_status[PSN_BIT_HI];

    always_ff @(posedge clk) begin
        if (rst) evt <= 1'b0;
        else     evt <= trig_en & sel_any;
    end

    assign unused_status = ^{fault_status, poison_status};

endmodule

// File: rtl/pa_match_trigger.sv
module pa_match_trigger
    import pamt_pkg::*;
#(
    parameter int unsigned INSTR_W   = 32,
    parameter int unsigned ADDR_W    = 40,
    parameter int unsigned STATUS_W  = 64,
    parameter int unsigned MATCH_LAT = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                mask_we,
    input  logic                cmp_we,
    input  logic [CFG_W-1:0]    cfg_wdata,
    input  logic                req_valid,
    input  logic [INSTR_W-1:0]  req_instr,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                trig_en,
    input  logic [STATUS_W-1:0] fault_status,
    input  logic [STATUS_W-1:0] poison_status,
    output logic                match_pulse,
    output logic                err_event
);

    trig_cfg_t   cfg_q;
    field_hits_t hits;
    logic        qualified;

    pamt_cfg_regs u_cfg (
        .clk       (clk),
        .rst       (rst),
        .mask_we   (mask_we),
        .cmp_we    (cmp_we),
        .cfg_wdata (cfg_wdata),
        .cfg_q     (cfg_q)
    );

    pamt_field_cmp #(
        .SRC_W(INSTR_W), .SRC_LO(OPA_SRC_LO), .CFG_LO(OPA_CFG_LO), .FIELD_W(OPA_W)
    ) u_opa (
        .src (req_instr),
        .cfg (cfg_q),
        .hit (hits.opa)
    );

    pamt_field_cmp #(
        .SRC_W(INSTR_W), .SRC_LO(OPB_SRC_LO), .CFG_LO(OPB_CFG_LO), .FIELD_W(OPB_W)
    ) u_opb (
        .src (req_instr),
        .cfg (cfg_q),
        .hit (hits.opb)
    );

    pamt_field_cmp #(
        .SRC_W(ADDR_W), .SRC_LO(ADR_SRC_LO), .CFG_LO(ADR_CFG_LO), .FIELD_W(ADR_W)
    ) u_adr (
        .src (req_addr),
        .cfg (cfg_q),
        .hit (hits.adr)
    );

    // all windows must agree in the cycle the request is valid
    assign qualified = req_valid & (&hits);

    pamt_delay #(.DEPTH(MATCH_LAT)) u_lat (
        .clk (clk),
        .rst (rst),
        .d   (qualified),
        .q   (match_pulse)
    );

    pamt_err_evt #(.STATUS_W(STATUS_W)) u_err (
        .clk           (clk),
        .rst           (rst),
        .trig_en       (trig_en),
        .fault_status  (fault_status),
        .poison_status (poison_status),
        .evt           (err_event)
    );

endmodule

// File: rtl/pamt_checker.sv
module pamt_checker
    import pamt_pkg::*;
#(
    parameter int unsigned INSTR_W   = 32,
    parameter int unsigned ADDR_W    = 40,
    parameter int unsigned STATUS_W  = 64,
    parameter int unsigned MATCH_LAT = 2
) (
    input logic                clk,
    input logic                rst,
    input logic                mask_we,
    input logic                cmp_we,
    input logic                req_valid,
    input logic [INSTR_W-1:0]  req_instr,
    input logic [ADDR_W-1:0]   req_addr,
    input trig_cfg_t           cfg,
    input logic                trig_en,
    input logic [STATUS_W-1:0] fault_status,
    input logic [STATUS_W-1:0] poison_status,
    input logic                match_pulse,
    input logic                err_event
);

    logic               exp_hit;
    logic               err_cond;
    logic [MATCH_LAT:0] hist;
    logic               unused_chk;

    // field windows written out by position, independent of the datapath
    assign exp_hit = req_valid &&
        ((req_instr[25:21] & cfg.mask[52:48]) == cfg.cmpv[52:48]) &&
        ((req_instr[18:13] & cfg.mask[45:40]) == cfg.cmpv[45:40]) &&
        ((req_addr[33:2]   & cfg.mask[33:2])  == cfg.cmpv[33:2]);

    assign err_cond = trig_en && (fault_status[35] || fault_status[36] ||
                                  poison_status[48] || poison_status[49]);

    always_ff @(posedge clk) begin
        if (rst) hist <= '0;
        else     hist <= {hist[MATCH_LAT-1:0], exp_hit};
    end

    assign unused_chk = ^{req_instr, req_addr, cfg, fault_status, poison_status, hist[MATCH_LAT]};

    // R5 / R7 / R12: every qualified request yields a pulse at the fixed latency
    p_pulse_follows_hit_r5: assert property (@(posedge clk) disable iff (rst)
        hist[MATCH_LAT-1] |-> match_pulse);

    // R5 / R4: no pulse without a qualified request at the fixed latency
    p_no_spurious_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        match_pulse |-> hist[MATCH_LAT-1]);

    // R6: event one cycle after its condition
    p_err_follows_cond_r6: assert property (@(posedge clk) disable iff (rst)
        err_cond |=> err_event);

    // R6: event only after its condition
    p_err_only_after_cond_r6: assert property (@(posedge clk) disable iff (rst)
        err_event |-> $past(err_cond));

    // R9: registers hold without their strobe
    p_mask_holds_r9: assert property (@(posedge clk) disable iff (rst)
        !mask_we |=> $stable(cfg.mask));

    p_cmp_holds_r9: assert property (@(posedge clk) disable iff (rst)
        !cmp_we |=> $stable(cfg.cmpv));

endmodule

bind pa_match_trigger pamt_checker #(
    .INSTR_W   (INSTR_W),
    .ADDR_W    (ADDR_W),
    .STATUS_W  (STATUS_W),
    .MATCH_LAT (MATCH_LAT)
) i_pamt_chk (
    .clk           (clk),
    .rst           (rst),
    .mask_we       (mask_we),
    .cmp_we        (cmp_we),
    .req_valid     (req_valid),
    .req_instr     (req_instr),
    .req_addr      (req_addr),
    .cfg           (cfg_q),
    .trig_en       (trig_en),
    .fault_status  (fault_status),
    .poison_status (poison_status),
    .match_pulse   (match_pulse),
    .err_event     (err_event)
);

// File: tb/test_pa_match_trigger.sv
module test_pa_match_trigger;

    localparam int unsigned IW = 32;
    localparam int unsigned AW = 40;
    localparam int unsigned SW = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mask_we = 1'b0;
    logic          cmp_we = 1'b0;
    logic [63:0]   cfg_wdata = '0;
    logic          req_valid = 1'b0;
    logic [IW-1:0] req_instr = '0;
    logic [AW-1:0] req_addr = '0;
    logic          trig_en = 1'b0;
    logic [SW-1:0] fault_status = '0;
    logic [SW-1:0] poison_status = '0;
    logic          match_pulse;
    logic          err_event;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pa_match_trigger i_pa_match_trigger (
        .clk           (clk),
        .rst           (rst),
        .mask_we       (mask_we),
        .cmp_we        (cmp_we),
        .cfg_wdata     (cfg_wdata),
        .req_valid     (req_valid),
        .req_instr     (req_instr),
        .req_addr      (req_addr),
        .trig_en       (trig_en),
        .fault_status  (fault_status),
        .poison_status (poison_status),
        .match_pulse   (match_pulse),
        .err_event     (err_event)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_instr(input logic [31:0] noise, input logic [4:0] fa,
                                             input logic [5:0] fb);
        logic [31:0] r;
        r = noise;
        r[25:21] = fa;
        r[18:13] = fb;
        return r;
    endfunction

    function automatic logic [39:0] mk_addr(input logic [39:0] noise, input logic [31:0] fadr);
        logic [39:0] r;
        r = noise;
        r[33:2] = fadr;
        return r;
    endfunction

    function automatic logic [63:0] mk_cfg(input logic [4:0] fa, input logic [5:0] fb,
                                           input logic [31:0] fadr);
        logic [63:0] r;
        r = '0;
        r[52:48] = fa;
        r[45:40] = fb;
        r[33:2]  = fadr;
        return r;
    endfunction

    task automatic wr_cfg(input logic [63:0] m, input logic [63:0] c);
        mask_we = 1'b1; cfg_wdata = m;
        @(negedge clk);
        mask_we = 1'b0; cmp_we = 1'b1; cfg_wdata = c;
        @(negedge clk);
        cmp_we = 1'b0;
    endtask

    // drive one request, confirm no early pulse, then check the pulse two cycles on
    task automatic probe(input logic v, input logic [31:0] ins, input logic [39:0] ad,
                         input logic exp, input string tag);
        req_valid = v; req_instr = ins; req_addr = ad;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " (one cycle)"}, 64'(match_pulse), 64'(0));
        @(negedge clk);
        check(tag, 64'(match_pulse), 64'(exp));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R8 match after reset", 64'(match_pulse), 64'(0));
        check("R8 event after reset", 64'(err_event), 64'(0));
        probe(1'b1, 32'hFFFF_FFFF, 40'hAB_CDEF_1234, 1'b1, "R8 cleared pattern matches");
        probe(1'b0, 32'hFFFF_FFFF, 40'hAB_CDEF_1234, 1'b0, "R4 invalid request");
    endtask

    task automatic t_opcode_a();
        wr_cfg(mk_cfg(5'h1F, 6'h00, 32'h0), mk_cfg(5'b10110, 6'h00, 32'h0));
        probe(1'b1, mk_instr(32'hA5A5_A5A5, 5'b10110, 6'h2A), 40'h12_3456_789A, 1'b1, "R1 field A equal");
        probe(1'b1, mk_instr(32'hA5A5_A5A5, 5'b10111, 6'h2A), 40'h12_3456_789A, 1'b0, "R1 field A differs");
        probe(1'b0, mk_instr(32'hA5A5_A5A5, 5'b10110, 6'h2A), 40'h12_3456_789A, 1'b0, "R4 valid low, fields equal");
    endtask

    task automatic t_opcode_b();
        wr_cfg(mk_cfg(5'h00, 6'h3F, 32'h0), mk_cfg(5'h00, 6'b101001, 32'h0));
        probe(1'b1, mk_instr(32'h5A5A_5A5A, 5'h03, 6'b101001), 40'h0, 1'b1, "R2 field B equal");
        probe(1'b1, mk_instr(32'h5A5A_5A5A, 5'h03, 6'b001001), 40'h0, 1'b0, "R2 field B differs");
    endtask

    task automatic t_addr();
        wr_cfg(mk_cfg(5'h00, 6'h00, 32'hFFFF_0000), mk_cfg(5'h00, 6'h00, 32'h1234_0000));
        probe(1'b1, 32'h0, mk_addr(40'hFF_0000_0003, 32'h1234_ABCD), 1'b1, "R3 masked address equal");
        probe(1'b1, 32'h0, mk_addr(40'h00_0000_0000, 32'h1235_0000), 1'b0, "R3 address differs");
    endtask

    task automatic t_all_fields();
        wr_cfg(mk_cfg(5'h1F, 6'h3F, 32'hFFFF_FFFF), mk_cfg(5'h0C, 6'h11, 32'hCAFE_0042));
        probe(1'b1, mk_instr(32'h0, 5'h0C, 6'h11), mk_addr(40'h0, 32'hCAFE_0042), 1'b1, "R7 all fields agree");
        probe(1'b1, mk_instr(32'h0, 5'h0D, 6'h11), mk_addr(40'h0, 32'hCAFE_0042), 1'b0, "R7 only field A off");
        probe(1'b1, mk_instr(32'h0, 5'h0C, 6'h10), mk_addr(40'h0, 32'hCAFE_0042), 1'b0, "R7 only field B off");
        probe(1'b1, mk_instr(32'h0, 5'h0C, 6'h11), mk_addr(40'h0, 32'hCAFE_0043), 1'b0, "R7 only address off");
    endtask

    task automatic t_outside_bits();
        logic [63:0] outside;
        outside = ~mk_cfg(5'h1F, 6'h3F, 32'hFFFF_FFFF);
        wr_cfg(outside, outside);
        probe(1'b1, 32'hFFFF_FFFF, 40'hFF_FFFF_FFFF, 1'b1, "R10 out-of-window bits ignored");
        probe(1'b1, 32'h0, 40'h0, 1'b1, "R10 out-of-window bits ignored, zero request");
    endtask

    task automatic t_write_timing();
        wr_cfg(64'h0, 64'h0);
        // write a compare bit under a zero mask bit while a request is in flight
        cmp_we = 1'b1; cfg_wdata = mk_cfg(5'b00001, 6'h00, 32'h0);
        req_valid = 1'b1; req_instr = 32'h1234_5678; req_addr = 40'h0;
        @(negedge clk);
        cmp_we = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 write-cycle request uses old compare", 64'(match_pulse), 64'(1));
        @(negedge clk);
        check("R11 compare one under mask zero never matches", 64'(match_pulse), 64'(0));
        probe(1'b1, mk_instr(32'h0, 5'b00001, 6'h0), 40'h0, 1'b0, "R11 field bits equal compare, still no match");
    endtask

    task automatic t_back_to_back();
        logic pat [4] = '{1'b1, 1'b1, 1'b0, 1'b1};
        wr_cfg(64'h0, 64'h0);
        for (int cyc = 0; cyc < 7; cyc++) begin
            if (cyc >= 2)
                check($sformatf("R12 pulse train cycle %0d", cyc), 64'(match_pulse),
                      64'((cyc - 2) < 4 ? pat[cyc-2] : 1'b0));
            req_valid = (cyc < 4) ? pat[cyc] : 1'b0;
            req_instr = 32'(cyc);
            @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    task automatic err_probe(input logic en, input logic [63:0] flt, input logic [63:0] psn,
                             input logic exp, input string tag);
        trig_en = en; fault_status = flt; poison_status = psn;
        @(negedge clk);
        trig_en = 1'b0; fault_status = '0; poison_status = '0;
        check(tag, 64'(err_event), 64'(exp));
        @(negedge clk);
        check({tag, " (released)"}, 64'(err_event), 64'(0));
    endtask

    task automatic t_err_event();
        err_probe(1'b0, 64'h1 << 35, 64'h3 << 48, 1'b0, "R6 enable low");
        err_probe(1'b1, 64'h1 << 35, 64'h0, 1'b1, "R6 fault bit 35");
        err_probe(1'b1, 64'h1 << 36, 64'h0, 1'b1, "R6 fault bit 36");
        err_probe(1'b1, 64'h0, 64'h1 << 48, 1'b1, "R6 poison bit 48");
        err_probe(1'b1, 64'h0, 64'h1 << 49, 1'b1, "R6 poison bit 49");
        err_probe(1'b1, ~((64'h1 << 35) | (64'h1 << 36)), ~((64'h1 << 48) | (64'h1 << 49)),
                  1'b0, "R6 other status bits ignored");
    endtask

    task automatic t_reset_clears();
        wr_cfg(mk_cfg(5'h1F, 6'h3F, 32'hFFFF_FFFF), mk_cfg(5'h15, 6'h2A, 32'h0BAD_F00D));
        probe(1'b1, 32'h0, 40'h0, 1'b0, "R8 pattern active before reset");
        do_reset();
        probe(1'b1, 32'h0, 40'h0, 1'b1, "R8 reset clears pattern");
    endtask

    initial begin
        t_reset();
        t_opcode_a();
        t_opcode_b();
        t_addr();
        t_all_fields();
        t_outside_bits();
        t_write_timing();
        t_back_to_back();
        t_err_event();
        t_reset_clears();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule